// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Arbiter

This block collects interrupt requests from eight sources and presents the core with one request line, the index of the winning source and its vector address. The sources are four active-low external pins, three timer flags and one serial flag. Each source has an enable bit and a priority bit, and a global enable gates all of them. Two priority levels exist. A pending high-level request can interrupt a running low-level handler. Nothing interrupts a running high-level handler.

The external pins are sampled once per machine cycle, marked by `tick`. Each pin triggers either on a falling edge or on a low level. In edge mode a request flag is latched and is cleared when that source is acknowledged. In level mode the flag tracks the inverted pin. The two extra external inputs (ext2 and ext3) keep their priority, enable, flag and trigger-type bits in one 8-bit control register, and each bit of that register is written on its own.

The core pulses `ack` when it takes the presented vector, and `reti` when a handler returns. A two-entry level stack records which levels are in service, so that `reti` returns to the level that was active before.

Top module: `irq_arbiter8`

## Requirements
- R1: Source index i (0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2, 6 ext2, 7 ext3) produces vector 03h + 8*i on `irq_vec` and i on `irq_src` whenever it is granted.
- R2: Among pending requests of the same level, the lowest source index wins.
- R3: A pending high-level request wins over any low-level request, whatever the source indices.
- R4: A source is pending only when its flag, its enable bit and `glob_en` are all 1. With `glob_en` = 0, `irq_req` stays 0.
- R5: While only a low-level handler is active, low-level requests are not presented and high-level requests are. With no handler active, either level may be presented.
- R6: While a high-level handler is active, `irq_req` stays 0.
- R7: `act_level` is {high active, low active}. An `ack` while `irq_req` = 1 sets the bit for the granted level. `reti` clears the high bit if it is set and otherwise clears the low bit. If `ack` and `reti` arrive in the same cycle, only `reti` takes effect.
- R8: In edge mode, a 1 then a 0 seen on two consecutive tick samples of a pin sets its flag in the next cycle. The flag then holds after the pin returns high, and an `ack` that grants that source clears it.
- R9: Pins are sampled only in cycles with `tick` = 1. A pulse that starts and ends while `tick` = 0 sets no flag.
- R10: In level mode, the flag takes the inverted pin value at each tick. `ack` does not clear it, and software writes to it are ignored.
- R11: `xctl_q` bits 7..0 read pri3, en3, flag3, type3, pri2, en2, flag2, type2. A bit write (`xbit_wr`, `xbit_sel`, `xbit_val`) updates only the selected bit. A type bit of 1 selects edge mode. A priority bit of 1 selects the high level.
- R12: After reset, `irq_req`, `act_level` and `xctl_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle strobe that qualifies pin sampling |
| ext_pin_n | input | 4 | External request pins ext0..ext3, active low |
| ext01_edge | input | 2 | Trigger type for ext0/ext1 (1 = falling edge) |
| tmr_flag | input | 3 | Timer0, timer1 and timer2 request flags |
| ser_flag | input | 1 | Serial port request flag |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Enables for sources 0..5 |
| src_pri | input | 6 | Priority bits for sources 0..5 (1 = high) |
| xbit_wr | input | 1 | Write strobe for one bit of the extended control register |
| xbit_sel | input | 3 | Index of the bit to write |
| xbit_val | input | 1 | Value written to the selected bit |
| ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Return from the current handler |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | VEC_W | Vector address of the granted source |
| irq_src | output | 3 | Index of the granted source |
| act_level | output | 2 | Levels in service {high, low} |
| xctl_q | output | 8 | Extended control register read-back |

## Verification
The bench builds the block with its default parameters: an 8-bit vector, base 03h and stride 8. With these values every one of the eight table entries can be reached and compared against the computed address. The table rows vary requests, enables and priority bits so that both the polling order and the override of high over low are covered. Directed sequences cover edge latching, the tick qualifier, level-mode flags ignoring `ack` and software writes, and nested high-over-low service unwinding through `reti`.

// File: rtl/irq8_pkg.sv
package irq8_pkg;
   localparam int SRC_N = 8;
   localparam int IDX_W = 3;
   localparam int EXT_N = 4;

   // read-back layout of the extended control register
   typedef struct packed {
      logic pri3;
      logic en3;
      logic flag3;
      logic type3;
      logic pri2;
      logic en2;
      logic flag2;
      logic type2;
   } xctl_t;

   // source index of external pin k
   function automatic logic [IDX_W-1:0] ext_src(input int k);
      case (k)
         0:       ext_src = 3'd0;
         1:       ext_src = 3'd2;
         2:       ext_src = 3'd6;
         default: ext_src = 3'd7;
      endcase
   endfunction
endpackage

// File: rtl/irq8_ext_detect.sv
module irq8_ext_detect #(
   parameter int PINS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [PINS-1:0] pin_n,
   input  logic [PINS-1:0] edge_mode,
   input  logic [PINS-1:0] clr,
   input  logic [PINS-1:0] sw_wr,
   input  logic [PINS-1:0] sw_val,
   output logic [PINS-1:0] flag
);
   for (genvar k = 0; k < PINS; k++) begin : g_pin
      logic smp_q;
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            smp_q  <= 1'b1;
            flag_q <= 1'b0;
         end else begin
            if (tick) smp_q <= pin_n[k];
            if (!edge_mode[k]) begin
               if (tick) flag_q <= ~pin_n[k];
            end else if (tick && smp_q && !pin_n[k]) begin
               flag_q <= 1'b1;
            end else if (clr[k]) begin
               flag_q <= 1'b0;
            end else if (sw_wr[k]) begin
               flag_q <= sw_val[k];
            end
         end
      end
      assign flag[k] = flag_q;
   end
endmodule

// File: rtl/irq8_prio_pick.sv
module irq8_prio_pick #(
   parameter int N = 8,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/irq8_level_stack.sv
module irq8_level_stack (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic       push_hi,
   input  logic       pop,
   output logic [1:0] act
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 2'b00;
      end else if (pop) begin
         if (act[1]) act[1] <= 1'b0;
         else        act[0] <= 1'b0;
      end else if (push) begin
         if (push_hi) act[1] <= 1'b1;
         else         act[0] <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_arbiter8.sv
module irq_arbiter8
   import irq8_pkg::*;
#(
   parameter int VEC_W      = 8,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [3:0]       ext_pin_n,
   input  logic [1:0]       ext01_edge,
   input  logic [2:0]       tmr_flag,
   input  logic             ser_flag,
   input  logic             glob_en,
   input  logic [5:0]       src_en,
   input  logic [5:0]       src_pri,
   input  logic             xbit_wr,
   input  logic [2:0]       xbit_sel,
   input  logic             xbit_val,
   input  logic             ack,
   input  logic             reti,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   output logic [2:0]       irq_src,
   output logic [1:0]       act_level,
   output logic [7:0]       xctl_q
);
   localparam int VEC_LAST = VEC_BASE + (SRC_N - 1) * VEC_STRIDE;

   if (VEC_LAST >= (2 ** VEC_W)) begin : g_bad_vec
      $error("vector table does not fit in VEC_W bits");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("VEC_STRIDE must be positive");
   end

   // extended control: per extra pin (index 0 = ext2, 1 = ext3)
   logic [1:0] x_type, x_en, x_pri;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_type <= '0;
         x_en   <= '0;
         x_pri  <= '0;
      end else if (xbit_wr) begin
         case (xbit_sel)
            3'd0: x_type[0] <= xbit_val;
            3'd2: x_en[0]   <= xbit_val;
            3'd3: x_pri[0]  <= xbit_val;
            3'd4: x_type[1] <= xbit_val;
            3'd6: x_en[1]   <= xbit_val;
            3'd7: x_pri[1]  <= xbit_val;
            default: ;
         endcase
      end
   end

   logic [EXT_N-1:0] ext_flag, ext_clr, sw_wr, sw_val;
   logic             ack_go;
   logic             grant_hi;

   assign sw_wr  = {xbit_wr && (xbit_sel == 3'd5), xbit_wr && (xbit_sel == 3'd1), 2'b00};
   assign sw_val = {4{xbit_val}};

   for (genvar k = 0; k < EXT_N; k++) begin : g_clr
      assign ext_clr[k] = ack_go && (irq_src == ext_src(k));
   end

   irq8_ext_detect #(.PINS(EXT_N)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .pin_n     (ext_pin_n),
      .edge_mode ({x_type, ext01_edge}),
      .clr       (ext_clr),
      .sw_wr     (sw_wr),
      .sw_val    (sw_val),
      .flag      (ext_flag)
   );

   logic [SRC_N-1:0] flags8, en8, pri8, pend;
   assign flags8 = {ext_flag[3], ext_flag[2], tmr_flag[2], ser_flag,
                    tmr_flag[1], ext_flag[1], tmr_flag[0], ext_flag[0]};
   assign en8    = {x_en, src_en};
   assign pri8   = {x_pri, src_pri};
   assign pend   = flags8 & en8 & {SRC_N{glob_en}};

   logic             hi_any, lo_any;
   logic [IDX_W-1:0] hi_idx, lo_idx;

   irq8_prio_pick #(.N(SRC_N)) u_hi (.req(pend & pri8),  .any(hi_any), .idx(hi_idx));
   irq8_prio_pick #(.N(SRC_N)) u_lo (.req(pend & ~pri8), .any(lo_any), .idx(lo_idx));

   logic grant_lo;
   assign grant_hi = hi_any && !act_level[1];
   assign grant_lo = !grant_hi && lo_any && (act_level == 2'b00);
   assign irq_req  = grant_hi || grant_lo;
   assign irq_src  = grant_hi ? hi_idx : lo_idx;
   assign irq_vec  = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(irq_src);
   assign ack_go   = ack && irq_req && !reti;

   irq8_level_stack u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (ack_go),
      .push_hi (grant_hi),
      .pop     (reti),
      .act     (act_level)
   );

   xctl_t xq;
   always_comb begin
      xq.pri3  = x_pri[1];
      xq.en3   = x_en[1];
      xq.flag3 = ext_flag[3];
      xq.type3 = x_type[1];
      xq.pri2  = x_pri[0];
      xq.en2   = x_en[0];
      xq.flag2 = ext_flag[2];
      xq.type2 = x_type[0];
   end
   assign xctl_q = xq;
endmodule

// File: rtl/irq_arbiter8_chk.sv
module irq_arbiter8_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       glob_en,
   input logic [5:0] src_pri,
   input logic       ack,
   input logic       reti,
   input logic       irq_req,
   input logic [2:0] irq_src,
   input logic [1:0] act_level,
   input logic [7:0] xctl_q
);
   logic [7:0] pri_all;
   assign pri_all = {xctl_q[7], xctl_q[3], src_pri};

   assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> !irq_req);

   assert_low_busy_only_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_level[0] && irq_req) |-> pri_all[irq_src]);

   assert_high_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_level[1] |-> !irq_req);

   assert_ack_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_req && !reti) |=> (act_level != 2'b00));

   assert_reti_unwinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && act_level == 2'b01) |=> (act_level == 2'b00));
endmodule

bind irq_arbiter8 irq_arbiter8_chk chk_i (.*);

// File: tb/irq_arbiter8_tb_top.sv
module irq_arbiter8_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic [3:0] ext_pin_n = 4'hF;
   logic [1:0] ext01_edge = 2'b00;
   logic [2:0] tmr_flag = 3'b000;
   logic       ser_flag = 1'b0;
   logic       glob_en = 1'b1;
   logic [5:0] src_en = '0;
   logic [5:0] src_pri = '0;
   logic       xbit_wr = 1'b0;
   logic [2:0] xbit_sel = '0;
   logic       xbit_val = 1'b0;
   logic       ack = 1'b0;
   logic       reti = 1'b0;
   logic       irq_req;
   logic [7:0] irq_vec;
   logic [2:0] irq_src;
   logic [1:0] act_level;
   logic [7:0] xctl_q;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_arbiter8 dut_i (.*);

   // {req8, en8, pri8, exp_req, exp_idx}
   localparam logic [27:0] TBL [9] = '{
      {8'h00, 8'hFF, 8'h00, 1'b0, 3'd0},
      {8'hFF, 8'hFF, 8'h00, 1'b1, 3'd0},
      {8'hFF, 8'hFF, 8'h80, 1'b1, 3'd7},
      {8'h30, 8'hFF, 8'h00, 1'b1, 3'd4},
      {8'hFF, 8'hFE, 8'h00, 1'b1, 3'd1},
      {8'hFF, 8'hFF, 8'h44, 1'b1, 3'd2},
      {8'hC0, 8'h40, 8'h00, 1'b1, 3'd6},
      {8'h20, 8'h00, 8'h00, 1'b0, 3'd0},
      {8'h0A, 8'hFF, 8'h08, 1'b1, 3'd3}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wr_bit(input int b, input logic v);
      @(negedge clk);
      xbit_wr = 1'b1; xbit_sel = 3'(b); xbit_val = v;
      @(negedge clk);
      xbit_wr = 1'b0;
   endtask

   task automatic set_xctl(input logic [7:0] v);
      for (int b = 0; b < 8; b++) wr_bit(b, v[b]);
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic pulse_reti();
      @(negedge clk); reti = 1'b1;
      @(negedge clk); reti = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 irq_req after reset", irq_req, 0);
      chk("R12 act_level after reset", act_level, 0);
      chk("R12 xctl_q after reset", xctl_q, 0);

      // table walk: all externals in level mode
      for (int r = 0; r < 9; r++) begin
         logic [7:0] rq, en, pr;
         {rq, en, pr} = TBL[r][27:4];
         wr_bit(2, en[6]); wr_bit(3, pr[6]);
         wr_bit(6, en[7]); wr_bit(7, pr[7]);
         @(negedge clk);
         src_en = en[5:0]; src_pri = pr[5:0];
         ext_pin_n = ~{rq[7], rq[6], rq[2], rq[0]};
         tmr_flag = {rq[5], rq[3], rq[1]};
         ser_flag = rq[4];
         @(negedge clk);
         chk($sformatf("R2/R3/R4 row %0d irq_req", r), irq_req, TBL[r][3]);
         if (TBL[r][3]) begin
            chk($sformatf("R2/R3 row %0d irq_src", r), irq_src, TBL[r][2:0]);
            chk($sformatf("R1 row %0d irq_vec", r), irq_vec, 3 + 8 * TBL[r][2:0]);
         end
      end

      // R4 global gate
      @(negedge clk);
      ext_pin_n = 4'h0; tmr_flag = 3'h7; ser_flag = 1'b1; src_en = 6'h3F;
      glob_en = 1'b0;
      @(negedge clk);
      chk("R4 glob_en off blocks all", irq_req, 0);
      ext_pin_n = 4'hF; tmr_flag = 3'h0; ser_flag = 1'b0; src_en = '0; src_pri = '0;
      glob_en = 1'b1;
      @(negedge clk);
      set_xctl(8'h00);
      chk("R11 xctl cleared", xctl_q, 8'h00);

      // R8 edge mode on ext2
      set_xctl(8'b0000_0101);
      chk("R11 type2/en2 bits", xctl_q, 8'b0000_0101);
      @(negedge clk); ext_pin_n[2] = 1'b0;
      @(negedge clk);
      chk("R8 edge sets flag2", xctl_q, 8'b0000_0111);
      chk("R1 ext2 vector", irq_vec, 8'h33);
      ext_pin_n[2] = 1'b1;
      @(negedge clk);
      chk("R8 flag2 held after pin high", xctl_q[1], 1);
      pulse_ack();
      chk("R8 ack clears edge flag2", xctl_q[1], 0);
      chk("R7 ack enters low level", act_level, 2'b01);

      // R5/R6/R7 preemption
      src_en[1] = 1'b1; tmr_flag[0] = 1'b1;
      @(negedge clk);
      chk("R5 low request held off by low handler", irq_req, 0);
      src_en[3] = 1'b1; src_pri[3] = 1'b1; tmr_flag[1] = 1'b1;
      @(negedge clk);
      chk("R5 high preempts low", irq_req, 1);
      chk("R5 high source index", irq_src, 3);
      chk("R1 timer1 vector", irq_vec, 8'h1B);
      pulse_ack();
      chk("R7 nested levels", act_level, 2'b11);
      chk("R6 nothing during high handler", irq_req, 0);
      pulse_reti();
      chk("R7 reti back to low", act_level, 2'b01);
      chk("R5 high pending again presented", irq_req, 1);
      tmr_flag[1] = 1'b0;
      pulse_reti();
      chk("R7 reti back to idle", act_level, 2'b00);
      chk("R5 low granted when idle", irq_src, 1);
      chk("R1 timer0 vector", irq_vec, 8'h0B);
      tmr_flag = 3'h0; src_en = '0; src_pri = '0;

      // R10 level mode on ext3
      set_xctl(8'b0100_0000);
      @(negedge clk); ext_pin_n[3] = 1'b0;
      @(negedge clk);
      chk("R10 level flag3 follows pin", xctl_q, 8'b0110_0000);
      chk("R1 ext3 vector", irq_vec, 8'h3B);
      pulse_ack();
      chk("R10 ack leaves level flag3", xctl_q[5], 1);
      wr_bit(5, 1'b0);
      chk("R10 write 0 ignored in level mode", xctl_q[5], 1);
      ext_pin_n[3] = 1'b1;
      @(negedge clk);
      chk("R10 flag3 drops with pin", xctl_q[5], 0);
      wr_bit(5, 1'b1);
      chk("R10 write 1 ignored in level mode", xctl_q[5], 0);
      pulse_reti();
      chk("R7 idle after reti", act_level, 2'b00);

      // R9 tick qualification in edge mode
      set_xctl(8'b0101_0000);
      @(negedge clk); tick = 1'b0; ext_pin_n[3] = 1'b0;
      @(negedge clk); ext_pin_n[3] = 1'b1;
      @(negedge clk); tick = 1'b1;
      @(negedge clk);
      chk("R9 pulse between ticks ignored", xctl_q[5], 0);
      chk("R9 no request from unsampled pulse", irq_req, 0);
      ext_pin_n[3] = 1'b0;
      @(negedge clk);
      chk("R9 edge on tick latched", xctl_q[5], 1);
      chk("R8 ext3 edge request", irq_src, 7);

      report();
   end
endmodule